// File: doc/BRIEF.md
# Programmable Clock Ratio Generator

This block turns one fast input clock into three clock-enable strobes: one for the processor core, one for the system bus and one for the peripheral domain. Each strobe is high for exactly one input-clock cycle and repeats at the input rate divided by a ratio. A 3-bit code in a frequency control word selects each ratio. The core and bus codes share one ratio table, and the peripheral code uses a second table. Neither table is limited to powers of two.

Software reaches the control word through a simple write/read port. A write changes all three rates. Each divider picks up its new ratio at its own next terminal count, so no strobe is ever shortened or doubled.

The peripheral ratio now in force is also driven out of the block. Downstream timers use it to scale their prescalers.

Top module: `clk_ratio_gen`

## Requirements
- R1: While reset is asserted, and on leaving reset, the control word reads 0x0E0A. That value selects core ratio 1, bus ratio 2 and peripheral ratio 4.
- R2: A write stores the full 16-bit word, unused upper bits included. The new value is visible on the read port in the cycle after the write.
- R3: The core code is bits 8:6 and the bus code is bits 5:3. Both map codes 0..7 to the ratios 1, 2, 3, 4, 5, 8, 8, 8. The out-of-range codes 6 and 7 still give a ratio of 8.
- R4: The peripheral code is bits 2:0. It maps codes 0..7 to the ratios 2, 3, 4, 6, 8, 8, 8, 8. Codes 5 to 7 give a ratio of 8, and the exported ratio only ever takes one of the values 2, 3, 4, 6 or 8.
- R5: A ratio of 1 holds the corresponding enable high in every cycle.
- R6: For a ratio N greater than 1, the enable is high for one cycle and then low for N-1 cycles.
- R7: A change of ratio takes effect only at the next terminal count of the affected divider. The interval already in progress completes at the old ratio.
- R8: The exported peripheral ratio changes only in a cycle in which the peripheral enable is high. It always equals the ratio of the peripheral interval that begins in that cycle.
- R9: In the first cycle after reset is released, all three enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| cpu_en | output | 1 | Core clock-enable strobe |
| bus_en | output | 1 | Bus clock-enable strobe |
| per_en | output | 1 | Peripheral clock-enable strobe |
| per_ratio | output | 4 | Peripheral divide ratio in force |

## Verification
Two events can land in the same cycle: a register write, and the terminal count of a divider that must decide which ratio to load. Random writes at random phases make this happen often. One directed case also lands a write two cycles after a core pulse at ratio 8. A cycle-accurate bench model checks each case: the interval in progress must finish at the old length, the next strobe must follow the new ratio, and the exported peripheral ratio may move only together with a peripheral strobe.

// File: rtl/crg_pkg.sv
package crg_pkg;
  localparam int FLD_W = 3;
  localparam int NLANE = 3;
  localparam int LANE_CPU = 0;
  localparam int LANE_BUS = 1;
  localparam int LANE_PER = 2;
  localparam int RAT_W = 4;
  localparam int MAX_RATIO = 8;
  localparam int CNT_W = $clog2(MAX_RATIO);

  // Field position: core at the top, peripheral at bit 0.
  function automatic int field_lo(input int lane);
    return (NLANE - 1 - lane) * FLD_W;
  endfunction

  function automatic logic [RAT_W-1:0] core_ratio(input logic [FLD_W-1:0] code);
    logic [RAT_W-1:0] r;
    case (code)
      3'd0: r = 4'd1;
      3'd1: r = 4'd2;
      3'd2: r = 4'd3;
      3'd3: r = 4'd4;
      3'd4: r = 4'd5;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

  function automatic logic [RAT_W-1:0] periph_ratio(input logic [FLD_W-1:0] code);
    logic [RAT_W-1:0] r;
    case (code)
      3'd0: r = 4'd2;
      3'd1: r = 4'd3;
      3'd2: r = 4'd4;
      3'd3: r = 4'd6;
      default: r = 4'd8;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/crg_ctrl_reg.sv
module crg_ctrl_reg #(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] RST_WORD = 16'h0E0A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_WORD;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/crg_field_decode.sv
module crg_field_decode #(
  parameter bit PERIPH = 1'b0
) (
  input  logic [crg_pkg::FLD_W-1:0] code,
  output logic [crg_pkg::RAT_W-1:0] ratio
);
  generate
    if (PERIPH) begin : g_per
      always_comb ratio = crg_pkg::periph_ratio(code);
    end else begin : g_core
      always_comb ratio = crg_pkg::core_ratio(code);
    end
  endgenerate
endmodule

// File: rtl/crg_strobe_div.sv
module crg_strobe_div #(
  parameter int RAT_W = 4,
  parameter int CNT_W = 3,
  parameter logic [RAT_W-1:0] RST_RATIO = 4'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAT_W-1:0] ratio_next,
  output logic             strobe,
  output logic [RAT_W-1:0] ratio_act
);
  logic [CNT_W-1:0] cnt;
  logic             term;

  assign term = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      strobe    <= 1'b0;
      ratio_act <= RST_RATIO;
    end else if (term) begin
      strobe    <= 1'b1;
      ratio_act <= ratio_next;
      cnt       <= CNT_W'(ratio_next - RAT_W'(1));
    end else begin
      strobe <= 1'b0;
      cnt    <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen #(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] RST_WORD = 16'h0E0A
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      cpu_en,
  output logic                      bus_en,
  output logic                      per_en,
  output logic [crg_pkg::RAT_W-1:0] per_ratio
);
  import crg_pkg::*;

  logic [REG_W-1:0]            ctrl_q;
  logic [NLANE-1:0]            lane_strobe;
  logic [NLANE-1:0][RAT_W-1:0] lane_ratio;

  crg_ctrl_reg #(.REG_W(REG_W), .RST_WORD(RST_WORD)) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata), .q(ctrl_q)
  );

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int LO = field_lo(g);
      localparam bit IS_PER = (g == LANE_PER);
      localparam logic [RAT_W-1:0] RR = IS_PER ? periph_ratio(RST_WORD[LO +: FLD_W])
                                               : core_ratio(RST_WORD[LO +: FLD_W]);
      logic [RAT_W-1:0] nxt;

      crg_field_decode #(.PERIPH(IS_PER)) u_dec (
        .code(ctrl_q[LO +: FLD_W]), .ratio(nxt)
      );

      crg_strobe_div #(.RAT_W(RAT_W), .CNT_W(CNT_W), .RST_RATIO(RR)) u_div (
        .clk(clk), .rst(rst), .ratio_next(nxt),
        .strobe(lane_strobe[g]), .ratio_act(lane_ratio[g])
      );
    end
  endgenerate

  assign reg_rdata = ctrl_q;
  assign cpu_en    = lane_strobe[LANE_CPU];
  assign bus_en    = lane_strobe[LANE_BUS];
  assign per_en    = lane_strobe[LANE_PER];
  assign per_ratio = lane_ratio[LANE_PER];
endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] RST_WORD = 16'h0E0A
) (
  input logic                                        clk,
  input logic                                        rst,
  input logic                                        reg_wr,
  input logic [REG_W-1:0]                            reg_wdata,
  input logic [REG_W-1:0]                            reg_rdata,
  input logic                                        per_en,
  input logic [crg_pkg::RAT_W-1:0]                   per_ratio,
  input logic [crg_pkg::NLANE-1:0]                   lane_strobe,
  input logic [crg_pkg::NLANE-1:0][crg_pkg::RAT_W-1:0] lane_ratio
);
  AST_RESET_WORD: assert property (@(posedge clk) rst |=> (reg_rdata == RST_WORD)); // R1
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_rdata == $past(reg_wdata))); // R2
  AST_PER_RATIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (per_ratio == 4'd2) || (per_ratio == 4'd3) || (per_ratio == 4'd4) ||
    (per_ratio == 4'd6) || (per_ratio == 4'd8)); // R4
  AST_RATIO_SWAP_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$stable(per_ratio) |-> per_en); // R8

  generate
    for (genvar g = 0; g < crg_pkg::NLANE; g++) begin : g_chk
      AST_UNITY_HELD: assert property (@(posedge clk) disable iff (rst)
        (lane_strobe[g] && lane_ratio[g] == 4'd1) |=> lane_strobe[g]); // R5
      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (lane_strobe[g] && lane_ratio[g] > 4'd1) |=> !lane_strobe[g]); // R6
    end
  endgenerate
endmodule

bind clk_ratio_gen crg_checker #(.REG_W(REG_W), .RST_WORD(RST_WORD)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .per_en(per_en), .per_ratio(per_ratio),
  .lane_strobe(lane_strobe), .lane_ratio(lane_ratio)
);

// File: tb/sim_clk_ratio_gen.sv
module sim_clk_ratio_gen;
  localparam logic [15:0] RST_W = 16'h0E0A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cpu_en, bus_en, per_en;
  logic [3:0]  per_ratio;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R6";

  always #4 clk = ~clk;

  clk_ratio_gen u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_en(cpu_en), .bus_en(bus_en),
    .per_en(per_en), .per_ratio(per_ratio)
  );

  function automatic int tb_core(input logic [2:0] c);
    int t[8] = '{1, 2, 3, 4, 5, 8, 8, 8};
    return t[c];
  endfunction

  function automatic int tb_per(input logic [2:0] c);
    int t[8] = '{2, 3, 4, 6, 8, 8, 8, 8};
    return t[c];
  endfunction

  function automatic logic lane_sig(input int i);
    return (i == 0) ? cpu_en : (i == 1) ? bus_en : per_en;
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // Behavioural model: a strobe starts each interval whose length is the ratio read at that moment.
  logic [15:0] m_reg;
  int          m_left [3];
  bit          m_en [3];
  int          m_pr;

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= RST_W;
      m_pr  <= tb_per(RST_W[2:0]);
      for (int i = 0; i < 3; i++) begin
        m_left[i] <= 0;
        m_en[i]   <= 1'b0;
      end
    end else begin
      if (reg_wr) m_reg <= reg_wdata;
      for (int i = 0; i < 3; i++) begin
        int r;
        r = (i == 2) ? tb_per(m_reg[2:0]) : tb_core(m_reg[8-3*i -: 3]);
        if (m_left[i] == 0) begin
          m_en[i]   <= 1'b1;
          m_left[i] <= r - 1;
          if (i == 2) m_pr <= r;
        end else begin
          m_en[i]   <= 1'b0;
          m_left[i] <= m_left[i] - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(tag, "cpu_en", int'(cpu_en), int'(m_en[0]));
      chk(tag, "bus_en", int'(bus_en), int'(m_en[1]));
      chk(tag, "per_en", int'(per_en), int'(m_en[2]));
      chk(tag, "per_ratio", int'(per_ratio), m_pr);
      chk(tag, "reg_rdata", int'(reg_rdata), int'(m_reg));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_word(input logic [15:0] w);
    reg_wr    = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic gap(input int i, output int g);
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!lane_sig(i) && guard < 64);
    g = 0;
    do begin @(negedge clk); g++; end while (!lane_sig(i) && g < 64);
  endtask

  initial begin
    int g;
    int k;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    chk("R1", "reg_rdata in reset", int'(reg_rdata), int'(RST_W));
    chk("R1", "per_ratio in reset", int'(per_ratio), 4);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "cpu_en first", int'(cpu_en), 1);
    chk("R9", "bus_en first", int'(bus_en), 1);
    chk("R9", "per_en first", int'(per_en), 1);
    chk("R1", "reg_rdata after reset", int'(reg_rdata), int'(RST_W));
    cmp_on = 1'b1;

    tag = "R2";
    write_word(16'hF1C5);
    chk("R2", "readback upper bits", int'(reg_rdata), 32'hF1C5);

    // Every code on every field, period measured from the strobes.
    for (int c = 0; c < 8; c++) begin
      tag = "R3";
      write_word({7'h2A, 3'(c), 3'(c), 3'(c)});
      repeat (20) @(negedge clk);
      gap(0, g); chk("R3", $sformatf("cpu gap code %0d", c), g, tb_core(3'(c)));
      gap(1, g); chk("R3", $sformatf("bus gap code %0d", c), g, tb_core(3'(c)));
      tag = "R4";
      gap(2, g); chk("R4", $sformatf("per gap code %0d", c), g, tb_per(3'(c)));
      chk("R8", $sformatf("per_ratio code %0d", c), int'(per_ratio), tb_per(3'(c)));
    end

    // R5: ratio 1 holds the core enable high.
    tag = "R5";
    write_word({7'h00, 3'd0, 3'd5, 3'd4});
    repeat (20) @(negedge clk);
    for (int n = 0; n < 12; n++) begin
      chk("R5", "cpu_en held", int'(cpu_en), 1);
      @(negedge clk);
    end

    // R7: change from ratio 8 to 1 mid-interval; the current gap stays 8.
    tag = "R7";
    write_word({7'h00, 3'd5, 3'd1, 3'd1});
    repeat (20) @(negedge clk);
    do @(negedge clk); while (!cpu_en);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 2) begin reg_wr = 1'b1; reg_wdata = {7'h00, 3'd0, 3'd1, 3'd1}; end
      if (k == 3) reg_wr = 1'b0;
    end while (!cpu_en && k < 64);
    chk("R7", "gap across change", k, 8);
    @(negedge clk);
    chk("R7", "new ratio in force", int'(cpu_en), 1);

    // R8: peripheral 2 -> 8, the exported value moves only with a strobe.
    tag = "R8";
    write_word({7'h00, 3'd1, 3'd1, 3'd0});
    repeat (20) @(negedge clk);
    write_word({7'h00, 3'd1, 3'd1, 3'd4});
    k = 0;
    while (per_ratio != 4'd8 && k < 20) begin @(negedge clk); k++; end
    chk("R8", "strobe with ratio swap", int'(per_en), 1);
    chk("R8", "swapped ratio", int'(per_ratio), 8);

    // Random writes at random phases, judged by the model every cycle.
    tag = "R6";
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 5 == 0) write_word(16'($urandom));
      else @(negedge clk);
    end

    cmp_on = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule